// File: doc/BRIEF.md
# Satellite Control Tone and Message Transmitter

This block produces the 22 kHz signalling tone that a satellite receiver uses to control dish-side equipment such as switches and positioners. A 19-bit phase accumulator, advanced by a programmable 16-bit increment, makes the square-wave carrier. A sequencer gates that carrier with the bit timing for pulse-width coded messages of one to six bytes, and for the two short tone bursts. A host reaches the block through a small synchronous register bus. It writes the message bytes, the phase increment and a control byte, then polls a ready flag until the transaction ends.

The control byte does three jobs. Bit 7 shuts the output path off. Bit 0 requests a steady tone while no transaction runs. Bits 3, 2 and 1, together with a length field in bits 6:4, start a message or a burst. Each message or burst is framed by a period of silence before the first tone and after the last one. While a transaction is in flight, the host's register writes are dropped. After the transaction, the host restores its earlier control byte, and the output returns to the steady tone or to silence as that byte selects.

Time is counted in units of half a millisecond. One unit is `UNIT_CYC` clock cycles: 48000 at a 96 MHz clock.

Top module: `diseqc_tx`

## Requirements
- R1: After reset, `ready` is 1, `tone_gate` and `line_out` are 0, the control byte and message bytes are 0, and the phase increment reads back as `INC_RESET` (default 120).
- R2: The increment is written low byte at address 2 and high byte at address 3, and both read back. `line_out` is bit 18 of a 19-bit accumulator that adds the increment every cycle, gated by `tone_gate`, so its frequency is increment × f_clk / 2^19.
- R3: With no transaction running, control bit 0 set and bit 7 clear, `tone_gate` is 1.
- R4: With control bit 7 set, `tone_gate` and `line_out` stay 0 in every state, including during a message.
- R5: A write to control (address 0) with bit 3 set, while idle, sends message bytes 0 .. L, where L is bits 6:4. A value of L above 5 is treated as 5, which sends six bytes. Message bytes are at addresses 8 to 13.
- R6: Each data bit lasts 3 units. A 0 is 2 units of tone and then 1 unit of silence. A 1 is 1 unit of tone and then 2 units of silence.
- R7: Byte 0 goes first. Each byte is sent MSB first and is followed by a parity bit that makes the count of ones in the nine bits odd.
- R8: A control write with bit 3 clear and bits 2:1 = 10 sends burst A, which is 25 units of unbroken tone. Bits 2:1 = 11 send burst B, which is nine logic-1 bits. Bit 3 has priority over bits 2:1.
- R9: At least 30 units of silence come before the first tone of a transaction, and at least 30 units follow the last tone before `ready` returns. The total length is (60 + 27·n) units for n bytes, 85 units for burst A and 87 units for burst B.
- R10: `ready` and status bit 0 (address 1) are 0 from the cycle after a starting write until the transaction ends, and 1 otherwise.
- R11: All register writes made while a transaction is in progress are ignored. Message bytes read back unchanged afterwards.
- R12: When a transaction ends, the output follows the control byte that is then stored. A host rewrite of that byte restores the steady tone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data for `addr`, combinational |
| tone_gate | output | 1 | Tone envelope, 1 while tone is on |
| line_out | output | 1 | Gated 22 kHz square wave, or the envelope when `SQUARE_OUT` is 0 |
| ready | output | 1 | 1 when idle and able to accept a command |

## Verification
The bench builds the block with `UNIT_CYC` = 4, which keeps a six-byte message under a thousand cycles. At that size every pulse width, guard period and total length can be measured exactly, cycle for cycle. `GUARD_UNITS`, `BURST_A_UNITS` and `MSG_BYTES` keep their defaults, so the bench sees the real framing ratios and the six-byte clamp. The bench writes increments of 0x4000 and 0x2000, which make the carrier period a whole number of cycles, so the count of output rising edges in a fixed window is an exact figure.

// File: rtl/diseqc_pkg.sv
package diseqc_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PRE,
      ST_MSG,
      ST_BURSTA,
      ST_BURSTB,
      ST_POST
   } seq_state_t;

   typedef struct packed {
      logic       msg;
      logic       burst_b;
      logic [2:0] last_byte;
   } cmd_t;

   localparam logic [3:0] ADDR_CTRL   = 4'h0;
   localparam logic [3:0] ADDR_STAT   = 4'h1;
   localparam logic [3:0] ADDR_INC_LO = 4'h2;
   localparam logic [3:0] ADDR_INC_HI = 4'h3;
   localparam logic [3:0] ADDR_MSG0   = 4'h8;

endpackage

// File: rtl/diseqc_regs.sv
module diseqc_regs
   import diseqc_pkg::*;
#(
   parameter int          MSG_BYTES = 6,
   parameter logic [15:0] INC_RESET = 16'd120
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [3:0]             addr,
   input  logic [7:0]             wdata,
   input  logic                   busy,
   output logic [7:0]             ctrl_q,
   output logic [15:0]            inc_q,
   output logic [MSG_BYTES*8-1:0] msg_flat,
   output logic [7:0]             rdata,
   output logic                   start,
   output cmd_t                   cmd
);
   localparam logic [2:0] LAST_MAX = 3'(MSG_BYTES - 1);

   logic wr_ok;
   assign wr_ok = wr_en & ~busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         inc_q    <= INC_RESET;
         msg_flat <= '0;
      end else if (wr_ok) begin
         if (addr == ADDR_CTRL)   ctrl_q      <= wdata;
         if (addr == ADDR_INC_LO) inc_q[7:0]  <= wdata;
         if (addr == ADDR_INC_HI) inc_q[15:8] <= wdata;
         for (int i = 0; i < MSG_BYTES; i++) begin
            if (addr == 4'(ADDR_MSG0 + i)) msg_flat[i*8 +: 8] <= wdata;
         end
      end
   end

   assign start = wr_ok && (addr == ADDR_CTRL) && (wdata[3] || wdata[2]);

   always_comb begin
      cmd.msg       = wdata[3];
      cmd.burst_b   = wdata[1];
      cmd.last_byte = (wdata[6:4] > LAST_MAX) ? LAST_MAX : wdata[6:4];
   end

   always_comb begin
      rdata = '0;
      case (addr)
         ADDR_CTRL:   rdata = ctrl_q;
         ADDR_STAT:   rdata = {7'b0, ~busy};
         ADDR_INC_LO: rdata = inc_q[7:0];
         ADDR_INC_HI: rdata = inc_q[15:8];
         default: begin
            if (addr[3] && (int'(addr[2:0]) < MSG_BYTES))
               rdata = msg_flat[{addr[2:0], 3'b000} +: 8];
         end
      endcase
   end
endmodule

// File: rtl/diseqc_phase.sv
module diseqc_phase #(
   parameter int ACC_W = 19,
   parameter int INC_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [INC_W-1:0] inc,
   output logic             square
);
   logic [ACC_W-1:0] acc_q;

   always_ff @(posedge clk) begin
      if (!rst_n) acc_q <= '0;
      else        acc_q <= acc_q + ACC_W'(inc);
   end

   assign square = acc_q[ACC_W-1];
endmodule

// File: rtl/diseqc_seq.sv
module diseqc_seq
   import diseqc_pkg::*;
#(
   parameter int UNIT_CYC      = 48000,
   parameter int GUARD_UNITS   = 30,
   parameter int BURST_A_UNITS = 25,
   parameter int MSG_BYTES     = 6
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start,
   input  cmd_t                   cmd,
   input  logic [MSG_BYTES*8-1:0] msg_flat,
   output logic                   busy,
   output logic                   gate
);
   localparam int CYC_W  = (UNIT_CYC > 1) ? $clog2(UNIT_CYC) : 1;
   localparam int MAX_U  = (GUARD_UNITS > BURST_A_UNITS) ? GUARD_UNITS : BURST_A_UNITS;
   localparam int UNIT_W = $clog2(MAX_U + 1);
   localparam logic [CYC_W-1:0]  CYC_LAST   = CYC_W'(UNIT_CYC - 1);
   localparam logic [UNIT_W-1:0] GUARD_LAST = UNIT_W'(GUARD_UNITS - 1);
   localparam logic [UNIT_W-1:0] BA_LAST    = UNIT_W'(BURST_A_UNITS - 1);

   seq_state_t        state_q, kind_q;
   logic [CYC_W-1:0]  cyc_q;
   logic [UNIT_W-1:0] unit_q;
   logic [1:0]        sub_q;
   logic [3:0]        bit_q;
   logic [2:0]        byte_q, last_q;
   logic              tick;
   logic [7:0]        cur_byte;
   logic              bit_val;

   assign tick = (cyc_q == CYC_LAST);

   always_comb begin
      cur_byte = msg_flat[{byte_q, 3'b000} +: 8];
      if (state_q == ST_BURSTB) bit_val = 1'b1;
      else if (bit_q[3])        bit_val = ~^cur_byte;
      else                      bit_val = cur_byte[3'd7 - bit_q[2:0]];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         kind_q  <= ST_MSG;
         cyc_q   <= '0;
         unit_q  <= '0;
         sub_q   <= '0;
         bit_q   <= '0;
         byte_q  <= '0;
         last_q  <= '0;
      end else if (state_q == ST_IDLE) begin
         cyc_q <= '0;
         if (start) begin
            state_q <= ST_PRE;
            unit_q  <= '0;
            last_q  <= cmd.last_byte;
            kind_q  <= cmd.msg ? ST_MSG : (cmd.burst_b ? ST_BURSTB : ST_BURSTA);
         end
      end else begin
         cyc_q <= tick ? '0 : cyc_q + 1'b1;
         if (tick) begin
            case (state_q)
               ST_PRE: begin
                  if (unit_q == GUARD_LAST) begin
                     state_q <= kind_q;
                     unit_q  <= '0;
                     sub_q   <= '0;
                     bit_q   <= '0;
                     byte_q  <= '0;
                  end else unit_q <= unit_q + 1'b1;
               end
               ST_BURSTA: begin
                  if (unit_q == BA_LAST) begin
                     state_q <= ST_POST;
                     unit_q  <= '0;
                  end else unit_q <= unit_q + 1'b1;
               end
               ST_MSG, ST_BURSTB: begin
                  if (sub_q == 2'd2) begin
                     sub_q <= '0;
                     if (bit_q == 4'd8) begin
                        bit_q <= '0;
                        if (state_q == ST_BURSTB || byte_q == last_q) begin
                           state_q <= ST_POST;
                           unit_q  <= '0;
                        end else byte_q <= byte_q + 1'b1;
                     end else bit_q <= bit_q + 1'b1;
                  end else sub_q <= sub_q + 1'b1;
               end
               ST_POST: begin
                  if (unit_q == GUARD_LAST) state_q <= ST_IDLE;
                  else                      unit_q  <= unit_q + 1'b1;
               end
               default: state_q <= ST_IDLE;
            endcase
         end
      end
   end

   assign busy = (state_q != ST_IDLE);

   always_comb begin
      case (state_q)
         ST_BURSTA:        gate = 1'b1;
         ST_MSG, ST_BURSTB: gate = (sub_q == 2'd0) || (sub_q == 2'd1 && !bit_val);
         default:          gate = 1'b0;
      endcase
   end
endmodule

// File: rtl/diseqc_tx.sv
module diseqc_tx
   import diseqc_pkg::*;
#(
   parameter int          UNIT_CYC      = 48000,
   parameter int          GUARD_UNITS   = 30,
   parameter int          BURST_A_UNITS = 25,
   parameter int          MSG_BYTES     = 6,
   parameter int          ACC_W         = 19,
   parameter logic [15:0] INC_RESET     = 16'd120,
   parameter bit          SQUARE_OUT    = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [3:0] addr,
   input  logic [7:0] wdata,
   output logic [7:0] rdata,
   output logic       tone_gate,
   output logic       line_out,
   output logic       ready
);
   localparam int INC_W = 16;

   if (MSG_BYTES < 1 || MSG_BYTES > 8) begin : g_bad_bytes
      $error("MSG_BYTES must lie in 1..8");
   end
   if (UNIT_CYC < 1 || GUARD_UNITS < 1 || BURST_A_UNITS < 1) begin : g_bad_timing
      $error("timing parameters must be positive");
   end
   if (ACC_W <= INC_W) begin : g_bad_acc
      $error("ACC_W must exceed the increment width");
   end

   logic [7:0]             ctrl_q;
   logic [INC_W-1:0]       inc_q;
   logic [MSG_BYTES*8-1:0] msg_flat;
   logic                   start, busy, seq_gate, square;
   cmd_t                   cmd;

   diseqc_regs #(.MSG_BYTES(MSG_BYTES), .INC_RESET(INC_RESET)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .busy(busy), .ctrl_q(ctrl_q), .inc_q(inc_q), .msg_flat(msg_flat),
      .rdata(rdata), .start(start), .cmd(cmd)
   );

   diseqc_phase #(.ACC_W(ACC_W), .INC_W(INC_W)) u_phase (
      .clk(clk), .rst_n(rst_n), .inc(inc_q), .square(square)
   );

   diseqc_seq #(
      .UNIT_CYC(UNIT_CYC), .GUARD_UNITS(GUARD_UNITS),
      .BURST_A_UNITS(BURST_A_UNITS), .MSG_BYTES(MSG_BYTES)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd), .msg_flat(msg_flat),
      .busy(busy), .gate(seq_gate)
   );

   assign tone_gate = ~ctrl_q[7] & (busy ? seq_gate : ctrl_q[0]);
   assign ready     = ~busy;

   if (SQUARE_OUT) begin : g_square
      assign line_out = tone_gate & square;
   end else begin : g_envelope
      assign line_out = tone_gate;
   end
endmodule

// File: rtl/diseqc_tx_chk.sv
module diseqc_tx_chk #(
   parameter int UNIT_CYC      = 48000,
   parameter int BURST_A_UNITS = 25,
   parameter int MSG_BYTES     = 6
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   wr_en,
   input logic [3:0]             addr,
   input logic [7:0]             wdata,
   input logic                   ready,
   input logic                   tone_gate,
   input logic                   line_out,
   input logic [MSG_BYTES*8-1:0] msg_flat
);
   localparam int RUN_MAX = BURST_A_UNITS * UNIT_CYC;
   int run_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                  run_q <= 0;
      else if (!ready && tone_gate) run_q <= run_q + 1;
      else                         run_q <= 0;
   end

   a_r10_start_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && wr_en && addr == 4'h0 && wdata[3]) |=> !ready);

   a_r9_quiet_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ready) |-> !tone_gate);

   a_r9_quiet_on_exit: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> !$past(tone_gate));

   a_r11_buffer_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(ready) |-> $stable(msg_flat));

   a_r2_line_gated: assert property (@(posedge clk) disable iff (!rst_n)
      !tone_gate |-> !line_out);

   a_r8_pulse_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      run_q <= RUN_MAX);
endmodule

bind diseqc_tx diseqc_tx_chk #(
   .UNIT_CYC(UNIT_CYC), .BURST_A_UNITS(BURST_A_UNITS), .MSG_BYTES(MSG_BYTES)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
   .ready(ready), .tone_gate(tone_gate), .line_out(line_out), .msg_flat(msg_flat)
);

// File: tb/tb_diseqc_tx.sv
module tb_diseqc_tx;
   localparam int U     = 4;
   localparam int GUARD = 30;
   localparam int BA    = 25;
   localparam int NB    = 6;
   localparam int LIMIT = 5000;
   localparam int NV    = 7;

   // {ctrl, byte0 .. byte5}
   localparam logic [55:0] VEC [NV] = '{
      {8'h08, 8'hE2, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00},
      {8'h28, 8'hE0, 8'h10, 8'h38, 8'h00, 8'h00, 8'h00},
      {8'h58, 8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h01, 8'h80},
      {8'h78, 8'h31, 8'hC7, 8'h0F, 8'hF0, 8'h66, 8'h99},
      {8'h04, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00},
      {8'h06, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00},
      {8'h0C, 8'h5B, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00}
   };

   logic       clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
   logic [3:0] addr = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       tone_gate, line_out, ready;

   int checks = 0, errors = 0;
   int plen [64];
   int npulse, busy_cyc, lead, trail;
   logic [7:0] rv;

   always #10 clk = ~clk;

   diseqc_tx #(.UNIT_CYC(U)) dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .tone_gate(tone_gate), .line_out(line_out), .ready(ready)
   );

   task automatic chk(input bit ok, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", what, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [7:0] d);
      @(negedge clk); addr = a; #1 d = rdata;
   endtask

   task automatic run_txn(input logic [7:0] c);
      int run;
      bit seen;
      wr(4'h0, c);
      npulse = 0; busy_cyc = 0; lead = 0; trail = 0; run = 0; seen = 0;
      while (!ready && busy_cyc < LIMIT) begin
         busy_cyc++;
         if (tone_gate) begin
            run++; seen = 1; trail = 0;
         end else begin
            if (run > 0) begin
               if (npulse < 64) plen[npulse] = run;
               npulse++; run = 0;
            end
            if (!seen) lead++;
            trail++;
         end
         @(negedge clk);
      end
      chk(busy_cyc < LIMIT, "R10 transaction ends", busy_cyc, LIMIT);
   endtask

   initial begin
      #(20 * 150000);
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(ready == 1'b1, "R1 ready after reset", ready, 1);
      chk(tone_gate == 1'b0 && line_out == 1'b0, "R1 output quiet after reset", tone_gate, 0);
      rd(4'h1, rv); chk(rv == 8'h01, "R10 status idle", rv, 1);
      rd(4'h2, rv); chk(rv == 8'd120, "R1 increment low reset", rv, 120);
      rd(4'h3, rv); chk(rv == 8'd0, "R1 increment high reset", rv, 0);
      rd(4'h8, rv); chk(rv == 8'd0, "R1 message byte reset", rv, 0);

      // table-driven messages and bursts: R5 R6 R7 R8 R9
      for (int v = 0; v < NV; v++) begin
         logic [7:0] c;
         int exp_len [64];
         int ne, n, exp_busy, mism;
         c = VEC[v][55:48];
         for (int i = 0; i < NB; i++) wr(4'(8 + i), VEC[v][47 - 8*i -: 8]);
         run_txn(c);
         ne = 0;
         if (c[3]) begin
            n = (c[6:4] > 3'd5) ? 6 : int'(c[6:4]) + 1;
            for (int b = 0; b < n; b++) begin
               logic [7:0] by;
               by = VEC[v][47 - 8*b -: 8];
               for (int j = 7; j >= 0; j--) begin exp_len[ne] = by[j] ? U : 2*U; ne++; end
               exp_len[ne] = (~^by) ? U : 2*U; ne++;
            end
            exp_busy = (2*GUARD + 27*n) * U;
         end else if (c[1] == 1'b0) begin
            exp_len[0] = BA * U; ne = 1;
            exp_busy = (2*GUARD + BA) * U;
         end else begin
            for (int j = 0; j < 9; j++) exp_len[j] = U;
            ne = 9;
            exp_busy = (2*GUARD + 27) * U;
         end
         chk(npulse == ne, "R5 R8 pulse count", npulse, ne);
         mism = 0;
         for (int k = 0; k < ne && k < npulse; k++) if (plen[k] != exp_len[k]) mism++;
         chk(mism == 0, "R6 R7 pulse widths", mism, 0);
         chk(busy_cyc == exp_busy, "R9 transaction length", busy_cyc, exp_busy);
         chk(lead == GUARD * U, "R9 leading silence", lead, GUARD * U);
         chk(trail >= GUARD * U, "R9 trailing silence", trail, GUARD * U);
      end

      // R2 increment and carrier frequency
      wr(4'h2, 8'h00); wr(4'h3, 8'h40); wr(4'h0, 8'h01);
      rd(4'h3, rv); chk(rv == 8'h40, "R2 increment readback", rv, 8'h40);
      chk(tone_gate == 1'b1, "R3 steady tone", tone_gate, 1);
      begin
         int rises; logic prev;
         rises = 0; prev = line_out;
         for (int k = 0; k < 320; k++) begin
            @(negedge clk);
            if (line_out && !prev) rises++;
            prev = line_out;
         end
         chk(rises == 10, "R2 carrier edges at 0x4000", rises, 10);
         wr(4'h3, 8'h20);
         rises = 0; prev = line_out;
         for (int k = 0; k < 320; k++) begin
            @(negedge clk);
            if (line_out && !prev) rises++;
            prev = line_out;
         end
         chk(rises == 5, "R2 carrier edges at 0x2000", rises, 5);
      end

      // R4 force-off
      wr(4'h0, 8'h81);
      begin
         int highs;
         highs = 0;
         for (int k = 0; k < 64; k++) begin
            @(negedge clk);
            if (tone_gate || line_out) highs++;
         end
         chk(highs == 0, "R4 forced off while idle", highs, 0);
      end
      wr(4'h8, 8'h00);
      run_txn(8'h88);
      chk(npulse == 0, "R4 forced off during message", npulse, 0);
      chk(busy_cyc == (2*GUARD + 27) * U, "R4 message still timed", busy_cyc, (2*GUARD + 27) * U);

      // R12 return to stored control after a transaction
      wr(4'h0, 8'h01);
      chk(tone_gate == 1'b1, "R12 tone before burst", tone_gate, 1);
      run_txn(8'h04);
      chk(lead == GUARD * U, "R9 tone suppressed before burst", lead, GUARD * U);
      chk(tone_gate == 1'b0, "R12 follows stored burst byte", tone_gate, 0);
      wr(4'h0, 8'h01);
      chk(tone_gate == 1'b1, "R12 tone restored by rewrite", tone_gate, 1);

      // R11 writes ignored while busy, R10 status
      wr(4'h8, 8'h3C);
      wr(4'h0, 8'h08);
      rd(4'h1, rv); chk(rv == 8'h00, "R10 status busy", rv, 0);
      wr(4'h8, 8'hFF);
      wr(4'h2, 8'h11);
      begin
         int w;
         w = 0;
         while (!ready && w < LIMIT) begin @(negedge clk); w++; end
      end
      rd(4'h8, rv); chk(rv == 8'h3C, "R11 message byte kept", rv, 8'h3C);
      rd(4'h2, rv); chk(rv == 8'h00, "R11 increment kept", rv, 0);
      rd(4'h1, rv); chk(rv == 8'h01, "R10 status idle again", rv, 1);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule